// File: doc/BRIEF.md
# Hybrid Cache-Block Pattern Compressor

This block squeezes one 128-byte memory block on its way to memory. The block arrives as sixteen 64-bit doublewords, one per accepted handshake. Each doubleword receives a 2-bit pattern code that says which of its 32-bit halves must be kept. The block has two code tables, and it picks one of them for the whole block by looking only at the first doubleword. The kept halves are gathered in a small internal store. When the last doubleword has been taken in, they are sent out one 32-bit word per cycle.

The block keeps a running total of bytes while the doublewords arrive. If a doubleword would push that total past a byte limit (48 by default), the block gives up for the rest of the block. It then reports the block as stored raw, and the consumer writes the original 128 bytes. A block that is zero everywhere is reported with its own state and carries no payload. When a block finishes, a one-cycle done pulse presents three results: the 2-bit block state, a 32-bit header of per-doubleword codes, and a count of 8-byte units.

Top module: `blockpat_compressor`

## Requirements
- R1: After reset, `idle` is 1 and `dw_ready`, `wd_valid` and `done` are 0.
- R2: A `blk_start` pulse while `idle` is high raises `dw_ready` on the next cycle. Exactly 16 doublewords are then taken, one on each cycle where `dw_valid` and `dw_ready` are both high, and `dw_ready` falls after the 16th. `dw_valid` has no effect while `dw_ready` is low.
- R3: The table is picked from doubleword 0 alone. If its two halves are equal, table A is used (state 00). Otherwise, if the bitwise AND of the halves is zero, table B is used (state 01). Otherwise table A is used.
- R4: In both tables, a doubleword that is all zero gets code 00 and keeps nothing. Code 01 means the upper half is zero, and the lower half is kept. Code 11 keeps the upper half and then the lower half, in that output order.
- R5: Code 10 means something different in each table. In table A it means the halves are equal and nonzero, and the lower half is kept. In table B it means the lower half is zero, and the upper half is kept. Code 10 is tested after code 01.
- R6: The code of doubleword i sits in header bits [31-2i : 30-2i], so doubleword 0 holds the top pair.
- R7: If a doubleword would bring the running total above 48 bytes, the block ends up as state 10. Its header and size are then 0 and no output word is sent.
- R8: A block whose kept data is exactly 48 bytes stays compressed. It sends 12 words and reports size 6.
- R9: A block of sixteen zero doublewords is reported as state 11, with header 0, size 0 and no output words.
- R10: A compressed block sends its kept words in doubleword order, one per `wd_valid` cycle. The number of words equals the byte total divided by 4. The size output is the byte total rounded up to whole 8-byte units.
- R11: `done` is high for one cycle. When words are sent, it comes in the cycle right after the last word. When no words are sent, it comes on the second cycle after the 16th doubleword is taken. `idle` is high again from the same cycle, and state, header and size hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| blk_start | input | 1 | Begins a block when `idle` is high |
| idle | output | 1 | Ready to accept `blk_start` |
| dw_valid | input | 1 | Doubleword on `dw_data` is valid |
| dw_ready | output | 1 | Doublewords are being accepted |
| dw_data | input | 64 | Incoming doubleword |
| wd_valid | output | 1 | `wd_data` carries a compressed word |
| wd_data | output | 32 | Compressed output word |
| done | output | 1 | One-cycle pulse: results valid |
| blk_state | output | 2 | 00 table A, 01 table B, 10 raw, 11 all zero |
| hdr | output | 32 | Per-doubleword codes |
| size8 | output | 4 | Compressed size in 8-byte units |

## Verification
The bench builds the block with its defaults: 16 doublewords per block and a 48-byte limit. These values put both sides of the limit within a single block. Six full doublewords land exactly on 48 bytes, and one more half word goes over. The first-doubleword choice of table is driven from all three of its branches. The later doublewords are chosen so that the two tables would give different codes for them. Odd word counts exercise the rounding of the size, and gaps in `dw_valid` are applied while a block is being loaded.

// File: rtl/blockpat_pkg.sv
package blockpat_pkg;

  localparam int HALF_W = 32;

  typedef enum logic [1:0] {
    BST_PATA = 2'b00,
    BST_PATB = 2'b01,
    BST_RAW  = 2'b10,
    BST_ZERO = 2'b11
  } blk_state_e;

  typedef enum logic [1:0] {
    PC_ZERO = 2'b00,
    PC_LOW  = 2'b01,
    PC_PAIR = 2'b10,
    PC_FULL = 2'b11
  } dw_code_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_LOAD  = 2'b01,
    PH_DRAIN = 2'b10
  } phase_e;

  // table choice from the leading doubleword: 1 selects table B
  function automatic logic pick_table_b(logic [HALF_W-1:0] hi, logic [HALF_W-1:0] lo);
    return ((hi ^ lo) != '0) && ((hi & lo) == '0);
  endfunction

  function automatic dw_code_e code_of(logic [HALF_W-1:0] hi, logic [HALF_W-1:0] lo,
                                       logic use_b);
    if (hi == '0 && lo == '0)       return PC_ZERO;
    else if (hi == '0)              return PC_LOW;
    else if (!use_b && hi == lo)    return PC_PAIR;
    else if (use_b && lo == '0)     return PC_PAIR;
    else                            return PC_FULL;
  endfunction

  function automatic logic [1:0] words_of(dw_code_e c);
    case (c)
      PC_ZERO: return 2'd0;
      PC_FULL: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // 32-bit words to 8-byte units, rounding up
  function automatic int units_of(int words);
    return (words + 1) / 2;
  endfunction

endpackage

// File: rtl/bp_classify.sv
module bp_classify
  import blockpat_pkg::*;
(
  input  logic [2*HALF_W-1:0] dw,
  input  logic                first,
  input  logic                table_b_q,
  output logic                use_b,
  output logic [1:0]          code,
  output logic [1:0]          nwords,
  output logic [HALF_W-1:0]   w0,
  output logic [HALF_W-1:0]   w1
);
  logic [HALF_W-1:0] hi, lo;
  dw_code_e          c;

  assign hi    = dw[2*HALF_W-1:HALF_W];
  assign lo    = dw[HALF_W-1:0];
  assign use_b = first ? pick_table_b(hi, lo) : table_b_q;

  always_comb begin
    c      = code_of(hi, lo, use_b);
    nwords = words_of(c);
    w1     = lo;
    case (c)
      PC_PAIR: w0 = use_b ? hi : lo;
      PC_FULL: w0 = hi;
      default: w0 = lo;
    endcase
  end

  assign code = c;

  // a doubleword kept whole never has a zero upper half
  always_comb begin
    if (nwords == 2'd2) assert_full_hi_R4: assert (hi != '0);
  end
endmodule

// File: rtl/bp_packbuf.sv
module bp_packbuf #(
  parameter int DEPTH = 12,
  parameter int WD_W  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [1:0]       wr_n,
  input  logic [WD_W-1:0]  w0,
  input  logic [WD_W-1:0]  w1,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [CNT_W-1:0] fill,
  output logic             fits,
  output logic [WD_W-1:0]  rd_data
);
  logic [WD_W-1:0]  mem [DEPTH];
  logic [CNT_W-1:0] fill_q, fill_p1;
  logic [CNT_W:0]   sum;
  logic             do_wr;

  assign sum     = {1'b0, fill_q} + {{(CNT_W-1){1'b0}}, wr_n};
  assign fits    = sum <= (CNT_W+1)'(DEPTH);
  assign fill_p1 = fill_q + CNT_W'(1);
  assign do_wr   = wr_en && fits;
  assign fill    = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fill_q <= '0;
    else if (clr)   fill_q <= '0;
    else if (do_wr) fill_q <= sum[CNT_W-1:0];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (do_wr) begin
        if (fill_q == CNT_W'(i) && wr_n != 2'd0)         mem[i] <= w0;
        else if (wr_n == 2'd2 && fill_p1 == CNT_W'(i))   mem[i] <= w1;
      end
    end
  end

  assign rd_data = (rd_idx < CNT_W'(DEPTH)) ? mem[rd_idx] : '0;

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));

  assert_reject_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fits && !clr) |=> $stable(fill_q));
endmodule

// File: rtl/blockpat_compressor.sv
module blockpat_compressor
  import blockpat_pkg::*;
#(
  parameter int DW_PER_BLK  = 16,
  parameter int LIMIT_BYTES = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_start,
  output logic        idle,
  input  logic        dw_valid,
  output logic        dw_ready,
  input  logic [63:0] dw_data,
  output logic        wd_valid,
  output logic [31:0] wd_data,
  output logic        done,
  output logic [1:0]  blk_state,
  output logic [31:0] hdr,
  output logic [3:0]  size8
);
  localparam int HDR_W   = 2 * DW_PER_BLK;
  localparam int IDX_W   = $clog2(DW_PER_BLK);
  localparam int LIMIT_W = LIMIT_BYTES / 4;
  localparam int CNT_W   = $clog2(LIMIT_W + 1);
  localparam int SIZE_W  = $clog2(DW_PER_BLK);

  phase_e            phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  rd_q, fill;
  logic              abort_q, nz_q, table_b_q;
  logic [HDR_W-1:0]  hdr_q, hdr_next;
  blk_state_e        fin_q, fin_next, state_o_q;
  logic [HDR_W-1:0]  hdr_o_q;
  logic [SIZE_W-1:0] size_o_q;
  logic              done_q;

  // named events for the checks below
  logic              accept, last_dw, abort_now, emit_ok, last_word, finish;
  logic              use_b, fits;
  logic [1:0]        code, nwords;
  logic [31:0]       w0, w1, rd_data;

  assign idle     = (phase_q == PH_IDLE);
  assign dw_ready = (phase_q == PH_LOAD);
  assign accept   = dw_ready && dw_valid;
  assign last_dw  = accept && (idx_q == IDX_W'(DW_PER_BLK - 1));

  bp_classify u_classify (
    .dw        (dw_data),
    .first     (idx_q == '0),
    .table_b_q (table_b_q),
    .use_b     (use_b),
    .code      (code),
    .nwords    (nwords),
    .w0        (w0),
    .w1        (w1)
  );

  bp_packbuf #(.DEPTH(LIMIT_W), .WD_W(32)) u_packbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (idle && blk_start),
    .wr_en   (accept && !abort_q),
    .wr_n    (nwords),
    .w0      (w0),
    .w1      (w1),
    .rd_idx  (rd_q),
    .fill    (fill),
    .fits    (fits),
    .rd_data (rd_data)
  );

  assign abort_now = accept && !abort_q && !fits;

  always_comb begin
    hdr_next = hdr_q;
    for (int k = 0; k < DW_PER_BLK; k++) begin
      if (idx_q == IDX_W'(k)) hdr_next[HDR_W-1-2*k -: 2] = code;
    end
  end

  always_comb begin
    if (abort_q || abort_now)                 fin_next = BST_RAW;
    else if (!nz_q && dw_data == '0)          fin_next = BST_ZERO;
    else if (use_b)                           fin_next = BST_PATB;
    else                                      fin_next = BST_PATA;
  end

  assign emit_ok   = (fin_q == BST_PATA) || (fin_q == BST_PATB);
  assign wd_valid  = (phase_q == PH_DRAIN) && emit_ok && (rd_q < fill);
  assign wd_data   = rd_data;
  assign last_word = wd_valid && (rd_q + CNT_W'(1) == fill);
  assign finish    = (phase_q == PH_DRAIN) && (!wd_valid || last_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      rd_q      <= '0;
      abort_q   <= 1'b0;
      nz_q      <= 1'b0;
      table_b_q <= 1'b0;
      hdr_q     <= '0;
      fin_q     <= BST_PATA;
      state_o_q <= BST_PATA;
      hdr_o_q   <= '0;
      size_o_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (blk_start) begin
            phase_q <= PH_LOAD;
            idx_q   <= '0;
            abort_q <= 1'b0;
            nz_q    <= 1'b0;
            hdr_q   <= '0;
          end
        end
        PH_LOAD: begin
          if (accept) begin
            idx_q <= idx_q + IDX_W'(1);
            if (dw_data != '0) nz_q <= 1'b1;
            if (idx_q == '0)   table_b_q <= use_b;
            if (!abort_q) begin
              if (fits) hdr_q   <= hdr_next;
              else      abort_q <= 1'b1;
            end
            if (last_dw) begin
              phase_q <= PH_DRAIN;
              rd_q    <= '0;
              fin_q   <= fin_next;
            end
          end
        end
        PH_DRAIN: begin
          if (wd_valid) rd_q <= rd_q + CNT_W'(1);
          if (finish) begin
            phase_q   <= PH_IDLE;
            done_q    <= 1'b1;
            state_o_q <= fin_q;
            hdr_o_q   <= (fin_q == BST_RAW) ? '0 : hdr_q;
            size_o_q  <= (fin_q == BST_RAW) ? '0 : SIZE_W'(units_of(int'(fill)));
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign blk_state = state_o_q;
  assign hdr       = hdr_o_q;
  assign size8     = size_o_q;

  assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle && dw_ready));

  assert_ready_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && blk_start) |=> dw_ready);

  assert_word_in_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> (!idle && !dw_ready && !done));

  assert_raw_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && blk_state == BST_RAW) |-> (hdr == '0 && size8 == '0));

  assert_zero_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && blk_state == BST_ZERO) |-> (hdr == '0 && size8 == '0));

  assert_size_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(size8) <= (LIMIT_W + 1) / 2));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);

  assert_hold_results_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(hdr) && $stable(size8) && $stable(blk_state))));
endmodule

// File: tb/blockpat_compressor_bench.sv
`timescale 1ns/1ps
module blockpat_compressor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_start = 1'b0;
  logic        dw_valid = 1'b0;
  logic [63:0] dw_data = '0;
  logic        idle, dw_ready, wd_valid, done;
  logic [31:0] wd_data, hdr;
  logic [1:0]  blk_state;
  logic [3:0]  size8;

  int n_checks = 0;
  int n_errors = 0;

  logic [63:0] blk   [16];
  logic [31:0] exp_w [32];
  logic [31:0] got_w [32];
  int          exp_n, exp_size;
  logic [1:0]  exp_state;
  logic [31:0] exp_hdr;

  always #4 clk = ~clk;

  blockpat_compressor u_blockpat_compressor (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .idle(idle),
    .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_data(dw_data),
    .wd_valid(wd_valid), .wd_data(wd_data), .done(done),
    .blk_state(blk_state), .hdr(hdr), .size8(size8)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // reference model written from the requirement text
  task automatic model();
    logic [31:0] h, l;
    bit tb;
    int bytes;
    h  = blk[0][63:32];
    l  = blk[0][31:0];
    tb = (h != l) && ((h & l) == 32'd0);
    exp_n = 0; exp_hdr = '0; bytes = 0;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] c;
      h = blk[i][63:32];
      l = blk[i][31:0];
      if (blk[i] == 64'd0) c = 2'b00;
      else if (h == 32'd0) begin c = 2'b01; exp_w[exp_n] = l; exp_n++; end
      else if (!tb && h == l) begin c = 2'b10; exp_w[exp_n] = l; exp_n++; end
      else if (tb && l == 32'd0) begin c = 2'b10; exp_w[exp_n] = h; exp_n++; end
      else begin c = 2'b11; exp_w[exp_n] = h; exp_w[exp_n+1] = l; exp_n += 2; end
      exp_hdr[31-2*i -: 2] = c;
    end
    bytes = exp_n * 4;
    if (bytes > 48) begin
      exp_state = 2'b10; exp_hdr = '0; exp_n = 0; exp_size = 0;
    end else if (exp_n == 0) begin
      exp_state = 2'b11; exp_size = 0;
    end else begin
      exp_state = tb ? 2'b01 : 2'b00;
      exp_size  = (bytes + 7) / 8;
    end
  endtask

  task automatic run_block(input string req, input bit gaps);
    int got_n, t, want_t;
    bit ready_ok, seen;
    model();
    got_n = 0; ready_ok = 1; seen = 0;
    @(negedge clk); blk_start = 1'b1;
    @(negedge clk); blk_start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (gaps && (i % 3 == 1)) begin
        dw_valid = 1'b0; dw_data = 64'hBAD0_BAD0_BAD0_BAD0;
        @(negedge clk);
      end
      if (!dw_ready) ready_ok = 0;
      dw_valid = 1'b1; dw_data = blk[i];
      @(negedge clk);
    end
    dw_valid = 1'b0; dw_data = '0;
    chk(ready_ok, "R2", {req, " dw_ready during load"}, 0, 1);
    chk(dw_ready == 1'b0, "R2", {req, " dw_ready after 16th"}, dw_ready, 0);
    want_t = (exp_n > 0) ? exp_n + 1 : 2;
    t = 0;
    while (!seen && t < 60) begin
      t++;
      if (wd_valid) begin
        if (got_n < 32) got_w[got_n] = wd_data;
        got_n++;
      end
      if (done) begin
        seen = 1;
        chk(blk_state == exp_state, req, "block state", blk_state, exp_state);
        chk(hdr == exp_hdr, "R6", {req, " header"}, hdr, exp_hdr);
        chk(int'(size8) == exp_size, "R10", {req, " size"}, size8, exp_size);
        chk(t == want_t, "R11", {req, " done cycle"}, t, want_t);
        chk(idle == 1'b1, "R11", {req, " idle at done"}, idle, 1);
      end else @(negedge clk);
    end
    chk(seen, "R11", {req, " done seen"}, seen, 1);
    chk(got_n == exp_n, "R10", {req, " word count"}, got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      chk(got_w[k] == exp_w[k], "R10", {req, " word"}, got_w[k], exp_w[k]);
    @(negedge clk);
    chk(done == 1'b0, "R11", {req, " done one cycle"}, done, 0);
    chk(blk_state == exp_state && hdr == exp_hdr, "R11", {req, " results held"}, hdr, exp_hdr);
  endtask

  task automatic clear_blk();
    for (int i = 0; i < 16; i++) blk[i] = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(idle == 1'b1, "R1", "idle after reset", idle, 1);
    chk(dw_ready == 1'b0, "R1", "dw_ready after reset", dw_ready, 0);
    chk(wd_valid == 1'b0, "R1", "wd_valid after reset", wd_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic t_all_zero();
    clear_blk();
    run_block("R9", 0);
  endtask

  task automatic t_table_a();
    clear_blk();
    blk[0] = 64'h1234_5678_1234_5678;  // equal halves -> A, code 10
    blk[2] = 64'h0000_0000_DEAD_BEEF;  // R4 code 01
    blk[3] = 64'hCAFE_0000_0000_0000;  // A: code 11 (B would give 10)
    blk[4] = 64'h1111_2222_3333_4444;  // code 11, hi then lo
    run_block("R3", 0);
    chk(exp_hdr[31:22] == 10'b10_00_01_11_11, "R5", "model table A codes", exp_hdr[31:22], 10'b1000011111);
  endtask

  task automatic t_table_b();
    clear_blk();
    blk[0] = 64'h0000_00FF_FF00_0000;  // disjoint halves -> B
    blk[1] = 64'hABCD_0000_0000_0000;  // B code 10 keeps hi
    blk[2] = 64'h5555_5555_5555_5555;  // B: code 11 (A would give 10)
    blk[3] = 64'h0000_0000_0000_0001;  // code 01
    run_block("R5", 0);
  endtask

  task automatic t_fallback();
    clear_blk();
    blk[0] = 64'hFFFF_0000_FFFF_0001;  // neither test -> A
    blk[1] = 64'h7777_7777_7777_7777;
    blk[2] = 64'h8000_0000_0000_0000;
    blk[5] = 64'h0000_0000_0000_0042;  // 6 words, also odd-free path
    blk[9] = 64'h0000_0000_0000_0043;  // 7 words -> size rounds up to 4
    run_block("R3", 1);
  endtask

  task automatic t_exact_limit();
    clear_blk();
    for (int i = 10; i < 16; i++) blk[i] = {32'h3000_0001 + 32'(i), 32'h1000_0003};
    run_block("R8", 0);
    chk(exp_n == 12 && exp_size == 6, "R8", "model at limit", exp_n, 12);
  endtask

  task automatic t_over_limit();
    clear_blk();
    for (int i = 0; i < 6; i++) blk[i] = {32'h3000_0001 + 32'(i), 32'h1000_0003};
    blk[6]  = 64'h0000_0000_0000_0009;  // 52 bytes -> raw
    blk[12] = 64'h0000_0000_0000_0001;
    run_block("R7", 1);
  endtask

  task automatic t_ignored_valid();
    // dw_valid while idle must not start or disturb a block
    @(negedge clk);
    dw_valid = 1'b1; dw_data = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    chk(dw_ready == 1'b0 && idle == 1'b1, "R2", "idle ignores dw_valid", dw_ready, 0);
    chk(done == 1'b0 && wd_valid == 1'b0, "R2", "no output from idle dw_valid", done, 0);
    dw_valid = 1'b0;
    t_table_a();
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_zero();
    t_table_a();
    t_table_b();
    t_fallback();
    t_exact_limit();
    t_over_limit();
    t_ignored_valid();
    t_table_b();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule